// File: doc/BRIEF.md
# Privileged Model-Specific Register Write Controller

This block carries out a single write into a 64-bit model-specific register. A request arrives on a valid/ready handshake with a 32-bit register index and two 32-bit data halves. Alongside it the core supplies its current privilege level, a real-address-mode flag, an intercept-mode flag and a pipeline-idle indication. The block checks the request and writes a small internal bank of implemented registers. It then reports exactly one outcome for each request: done, general-protection fault (error code zero), or intercept.

Writes that pass every check are serializing. The block holds the request until the pipeline reports idle, and only then commits the value and reports done. A successful write to one of the memory-type-range registers also produces a one-cycle pulse that invalidates every TLB entry, global entries included. Faulting and intercepted requests finish at once. The whole bank is visible on a flat output so that the surrounding logic can observe its contents.

Top module: `msr_write_ctl`

## Requirements
- R1: A successful write stores a 64-bit value whose bits 63:32 come from `req_hi` and whose bits 31:0 come from `req_lo`. The value goes into the slot that the index names. On `reg_state`, slot s occupies bits [s*64 +: 64]. Indices 0x100..0x107 map to slots 0..7 (general registers). Indices 0x200..0x203 map to slots 8..11 (memory-type-range registers).
- R2: When intercept mode is off, a request is refused unless `cur_priv` is 0 or `real_mode` is 1. A refused request reports a general-protection fault and leaves every register unchanged.
- R3: Any index outside the two implemented ranges of R1 reports a general-protection fault and leaves every register unchanged. The privilege check of R2 is applied before this check.
- R4: When `icpt_mode` is 1 at acceptance, the request reports intercept, whatever its privilege and index, and changes no register.
- R5: A request that passes every check waits for serialization. Neither `rsp_valid` nor a register change occurs before a cycle in which `pipe_idle` is 1. `req_ready` stays 0 during the wait, so no other request is taken.
- R6: `tlb_flush_all` is high for exactly one cycle, together with a done response, when the committed write targets a memory-type-range slot (8..11). It never rises for general slots, faults or intercepts.
- R7: After reset, slot s holds bits 63:32 = 0x5A000000 + s and bits 31:0 = 0x00000F00 + s. After reset `req_ready` is 1, `rsp_valid` is 0 and `tlb_flush_all` is 0.
- R8: Each accepted request produces exactly one `rsp_valid` pulse of one cycle. A fault or intercept gives its pulse in the cycle after acceptance, without waiting for `pipe_idle`.
- R9: `rsp_kind` encodes the outcome as 2'b00 done, 2'b01 general-protection fault, and 2'b10 intercept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Controller can take a request |
| req_index | input | 32 | Register index |
| req_hi | input | 32 | Upper data half |
| req_lo | input | 32 | Lower data half |
| cur_priv | input | 2 | Current privilege level |
| real_mode | input | 1 | Core is in real-address mode |
| icpt_mode | input | 1 | Intercept mode active |
| pipe_idle | input | 1 | Pipeline drained, write may commit |
| rsp_valid | output | 1 | One-cycle outcome strobe |
| rsp_kind | output | 2 | Outcome code |
| tlb_flush_all | output | 1 | Invalidate all TLB entries including global |
| reg_state | output | 768 | Flattened contents of the register bank |

## Verification
On every cycle the assertions check five things. A done strobe only follows a sampled pipeline-idle. The bank never changes without a write strobe. Faults and intercepts leave the bank untouched. Intercept wins whenever its flag was set at acceptance. The flush pulse lasts one cycle and always comes with a done outcome. Only the bench's scenarios can show the correct placement of the data halves, the mapping of index to slot and the reset values. They also show that an unimplemented or badly privileged request faults, and that a request held during the serialization wait is refused.

// File: rtl/msr_wr_pkg.sv
package msr_wr_pkg;

    typedef enum logic [1:0] {
        OUT_DONE = 2'b00,
        OUT_GPF  = 2'b01,
        OUT_ICPT = 2'b10
    } outcome_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } ctl_state_e;

    localparam int unsigned DATA_W = 64;

endpackage

// File: rtl/msr_index_decode.sv
module msr_index_decode #(
    parameter int unsigned NUM_GEN   = 8,
    parameter int unsigned NUM_MTRR  = 4,
    parameter logic [31:0] GEN_BASE  = 32'h0000_0100,
    parameter logic [31:0] MTRR_BASE = 32'h0000_0200,
    localparam int unsigned NUM_SLOTS = NUM_GEN + NUM_MTRR,
    localparam int unsigned SLOT_W    = $clog2(NUM_SLOTS)
) (
    input  logic [31:0]       index,
    output logic              hit,
    output logic              is_mtrr,
    output logic [SLOT_W-1:0] slot
);

    logic [NUM_SLOTS-1:0] match;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        if (g < NUM_GEN) begin : g_gen
            assign match[g] = (index == GEN_BASE + 32'(g));
        end else begin : g_mtrr
            assign match[g] = (index == MTRR_BASE + 32'(g - NUM_GEN));
        end
    end

    always_comb begin
        slot = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (match[i]) slot = SLOT_W'(i);
        end
    end

    assign hit     = |match;
    assign is_mtrr = |match[NUM_SLOTS-1:NUM_GEN];

    // R3: at most one implemented slot matches any index
    always_comb begin
        unique_match_chk: assert ($onehot0(match));
    end

endmodule

// File: rtl/msr_reg_bank.sv
module msr_reg_bank #(
    parameter int unsigned NUM_SLOTS = 12,
    localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS),
    localparam int unsigned DW       = msr_wr_pkg::DATA_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [SLOT_W-1:0]       wr_slot,
    input  logic [DW-1:0]           wr_data,
    output logic [NUM_SLOTS*DW-1:0] contents
);

    logic [DW-1:0] regs_d [NUM_SLOTS];
    logic [DW-1:0] regs_q [NUM_SLOTS];

    always_comb begin
        for (int i = 0; i < NUM_SLOTS; i++) begin
            regs_d[i] = regs_q[i];
            if (wr_en && (wr_slot == SLOT_W'(i))) regs_d[i] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                regs_q[i] <= {32'h5A00_0000 + 32'(i), 32'h0000_0F00 + 32'(i)};
            end
        end else begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                regs_q[i] <= regs_d[i];
            end
        end
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_out
        assign contents[g*DW +: DW] = regs_q[g];
    end

    // R2 R3 R4: bank holds its value unless a write strobe was given
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> $stable(contents));

endmodule

// File: rtl/msr_write_ctl.sv
module msr_write_ctl
    import msr_wr_pkg::*;
#(
    parameter int unsigned NUM_GEN   = 8,
    parameter int unsigned NUM_MTRR  = 4,
    parameter logic [31:0] GEN_BASE  = 32'h0000_0100,
    parameter logic [31:0] MTRR_BASE = 32'h0000_0200,
    localparam int unsigned NUM_SLOTS = NUM_GEN + NUM_MTRR,
    localparam int unsigned SLOT_W    = $clog2(NUM_SLOTS),
    localparam int unsigned DW        = msr_wr_pkg::DATA_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [31:0]             req_index,
    input  logic [31:0]             req_hi,
    input  logic [31:0]             req_lo,
    input  logic [1:0]              cur_priv,
    input  logic                    real_mode,
    input  logic                    icpt_mode,
    input  logic                    pipe_idle,
    output logic                    rsp_valid,
    output logic [1:0]              rsp_kind,
    output logic                    tlb_flush_all,
    output logic [NUM_SLOTS*DW-1:0] reg_state
);

    typedef struct packed {
        ctl_state_e        state;
        logic [SLOT_W-1:0] slot;
        logic [DW-1:0]     data;
        logic              mtrr;
        logic              rsp_valid;
        outcome_e          kind;
        logic              tlb;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              dec_hit;
    logic              dec_mtrr;
    logic [SLOT_W-1:0] dec_slot;
    logic              priv_ok;
    logic              commit;

    msr_index_decode #(
        .NUM_GEN  (NUM_GEN),
        .NUM_MTRR (NUM_MTRR),
        .GEN_BASE (GEN_BASE),
        .MTRR_BASE(MTRR_BASE)
    ) u_dec (
        .index  (req_index),
        .hit    (dec_hit),
        .is_mtrr(dec_mtrr),
        .slot   (dec_slot)
    );

    assign priv_ok = (cur_priv == 2'd0) || real_mode;
    assign commit  = (ctl_q.state == ST_WAIT) && pipe_idle;

    always_comb begin
        ctl_d           = ctl_q;
        ctl_d.rsp_valid = 1'b0;
        ctl_d.tlb       = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    if (icpt_mode) begin
                        ctl_d.rsp_valid = 1'b1;
                        ctl_d.kind      = OUT_ICPT;
                    end else if (!priv_ok || !dec_hit) begin
                        ctl_d.rsp_valid = 1'b1;
                        ctl_d.kind      = OUT_GPF;
                    end else begin
                        ctl_d.state = ST_WAIT;
                        ctl_d.slot  = dec_slot;
                        ctl_d.data  = {req_hi, req_lo};
                        ctl_d.mtrr  = dec_mtrr;
                    end
                end
            end
            ST_WAIT: begin
                if (pipe_idle) begin
                    ctl_d.state     = ST_IDLE;
                    ctl_d.rsp_valid = 1'b1;
                    ctl_d.kind      = OUT_DONE;
                    ctl_d.tlb       = ctl_q.mtrr;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_IDLE, slot: '0, data: '0, mtrr: 1'b0,
                       rsp_valid: 1'b0, kind: OUT_DONE, tlb: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    msr_reg_bank #(
        .NUM_SLOTS(NUM_SLOTS)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (commit),
        .wr_slot (ctl_q.slot),
        .wr_data (ctl_q.data),
        .contents(reg_state)
    );

    assign req_ready     = (ctl_q.state == ST_IDLE);
    assign rsp_valid     = ctl_q.rsp_valid;
    assign rsp_kind      = ctl_q.kind;
    assign tlb_flush_all = ctl_q.tlb;

    // R5
    serialize_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == OUT_DONE) |-> $past(pipe_idle));

    // R4
    icpt_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && req_ready && icpt_mode) |-> (rsp_valid && rsp_kind == OUT_ICPT));

    // R2
    no_change_on_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind != OUT_DONE) |-> $stable(reg_state));

    // R6
    flush_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_flush_all |-> (rsp_valid && rsp_kind == OUT_DONE));

    // R6
    flush_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_flush_all |=> !tlb_flush_all);

    // R9
    kind_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_kind != 2'b11));

endmodule

// File: tb/msr_write_ctl_test.sv
module msr_write_ctl_test;

    localparam int CLK_PERIOD = 10;
    localparam int NSLOT = 12;

    typedef struct packed {
        logic [31:0] idx;
        logic [31:0] hi;
        logic [31:0] lo;
        logic [1:0]  priv;
        logic        rmode;
        logic        icpt;
        logic [1:0]  kind;
        logic        tlb;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VEC [NVEC] = '{
        '{32'h100, 32'hAAAA_0001, 32'h1111_0001, 2'd0, 1'b0, 1'b0, 2'b00, 1'b0},
        '{32'h203, 32'hBBBB_0203, 32'h2222_0203, 2'd0, 1'b0, 1'b0, 2'b00, 1'b1},
        '{32'h107, 32'hCCCC_0107, 32'h3333_0107, 2'd3, 1'b1, 1'b0, 2'b00, 1'b0},
        '{32'h102, 32'hDEAD_0102, 32'hBEEF_0102, 2'd3, 1'b0, 1'b0, 2'b01, 1'b0},
        '{32'h180, 32'h0000_0180, 32'h0000_0180, 2'd0, 1'b0, 1'b0, 2'b01, 1'b0},
        '{32'h101, 32'h1234_5678, 32'h9ABC_DEF0, 2'd0, 1'b0, 1'b1, 2'b10, 1'b0},
        '{32'h300, 32'h0000_0300, 32'h0000_0300, 2'd2, 1'b0, 1'b1, 2'b10, 1'b0},
        '{32'h050, 32'h0000_0050, 32'h0000_0050, 2'd1, 1'b0, 1'b0, 2'b01, 1'b0},
        '{32'h200, 32'hFFFF_0200, 32'h0000_FFFF, 2'd0, 1'b1, 1'b0, 2'b00, 1'b1},
        '{32'h204, 32'h0000_0204, 32'h0000_0204, 2'd0, 1'b0, 1'b0, 2'b01, 1'b0},
        '{32'h108, 32'h0000_0108, 32'h0000_0108, 2'd0, 1'b0, 1'b0, 2'b01, 1'b0}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [31:0]       req_index = '0;
    logic [31:0]       req_hi = '0;
    logic [31:0]       req_lo = '0;
    logic [1:0]        cur_priv = '0;
    logic              real_mode = 1'b0;
    logic              icpt_mode = 1'b0;
    logic              pipe_idle = 1'b0;
    logic              rsp_valid;
    logic [1:0]        rsp_kind;
    logic              tlb_flush_all;
    logic [NSLOT*64-1:0] reg_state;

    logic [63:0] model [NSLOT];
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    msr_write_ctl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_index(req_index), .req_hi(req_hi), .req_lo(req_lo),
        .cur_priv(cur_priv), .real_mode(real_mode), .icpt_mode(icpt_mode),
        .pipe_idle(pipe_idle), .rsp_valid(rsp_valid), .rsp_kind(rsp_kind),
        .tlb_flush_all(tlb_flush_all), .reg_state(reg_state)
    );

    task automatic check(input logic ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_bank(input string req);
        int bad = -1;
        for (int s = 0; s < NSLOT; s++) begin
            if (reg_state[s*64 +: 64] !== model[s] && bad < 0) bad = s;
        end
        if (bad < 0) check(1'b1, req, "bank", '0, '0);
        else check(1'b0, req, $sformatf("bank slot %0d", bad),
                   reg_state[bad*64 +: 64], model[bad]);
    endtask

    function automatic int slot_of(input logic [31:0] idx);
        if (idx >= 32'h100 && idx <= 32'h107) return int'(idx - 32'h100);
        if (idx >= 32'h200 && idx <= 32'h203) return 8 + int'(idx - 32'h200);
        return -1;
    endfunction

    task automatic run_vec(input vec_t v);
        string tag;
        tag = v.icpt ? "R4" : (v.kind == 2'b01) ? "R2 R3" : "R1";
        @(negedge clk);
        req_valid = 1'b1; req_index = v.idx; req_hi = v.hi; req_lo = v.lo;
        cur_priv = v.priv; real_mode = v.rmode; icpt_mode = v.icpt; pipe_idle = 1'b0;
        @(negedge clk);
        req_valid = 1'b0; icpt_mode = 1'b0;
        if (v.kind != 2'b00) begin
            check(rsp_valid === 1'b1, "R8", "fault strobe", 64'(rsp_valid), 64'd1);
            check(rsp_kind === v.kind, tag, "kind R9", 64'(rsp_kind), 64'(v.kind));
            check(tlb_flush_all === 1'b0, "R6", "no flush on fault", 64'(tlb_flush_all), 64'd0);
            check_bank(tag);
        end else begin
            check(rsp_valid === 1'b0, "R5", "no early done", 64'(rsp_valid), 64'd0);
            check(req_ready === 1'b0, "R5", "ready low in wait", 64'(req_ready), 64'd0);
            check_bank("R5");
            req_valid = 1'b1; req_index = 32'h101; req_hi = '1; req_lo = '1; cur_priv = 2'd0;
            @(negedge clk);
            check(rsp_valid === 1'b0, "R5", "still waiting", 64'(rsp_valid), 64'd0);
            req_valid = 1'b0; pipe_idle = 1'b1;
            @(negedge clk);
            pipe_idle = 1'b0;
            model[slot_of(v.idx)] = {v.hi, v.lo};
            check(rsp_valid === 1'b1, "R5", "done strobe", 64'(rsp_valid), 64'd1);
            check(rsp_kind === 2'b00, "R9", "done kind", 64'(rsp_kind), 64'd0);
            check(tlb_flush_all === v.tlb, "R6", "flush", 64'(tlb_flush_all), 64'(v.tlb));
            check_bank(tag);
        end
        @(negedge clk);
        check(rsp_valid === 1'b0, "R8", "single strobe", 64'(rsp_valid), 64'd0);
        check(tlb_flush_all === 1'b0, "R6", "flush one cycle", 64'(tlb_flush_all), 64'd0);
        check_bank("R8");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int s = 0; s < NSLOT; s++)
            model[s] = {32'h5A00_0000 + 32'(s), 32'h0000_0F00 + 32'(s)};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7 reset state
        check(req_ready === 1'b1, "R7", "ready after reset", 64'(req_ready), 64'd1);
        check(rsp_valid === 1'b0, "R7", "no strobe after reset", 64'(rsp_valid), 64'd0);
        check(tlb_flush_all === 1'b0, "R7", "no flush after reset", 64'(tlb_flush_all), 64'd0);
        check_bank("R7");

        for (int i = 0; i < NVEC; i++) run_vec(VEC[i]);

        // R8 back-to-back faults, each with its own strobe
        @(negedge clk);
        req_valid = 1'b1; req_index = 32'h999; cur_priv = 2'd0; icpt_mode = 1'b0;
        @(negedge clk);
        check(rsp_valid === 1'b1 && rsp_kind === 2'b01, "R8", "first fault",
              64'({rsp_valid, rsp_kind}), 64'b101);
        icpt_mode = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; icpt_mode = 1'b0;
        check(rsp_valid === 1'b1 && rsp_kind === 2'b10, "R8", "second strobe intercept",
              64'({rsp_valid, rsp_kind}), 64'b110);
        check_bank("R4");

        // R6 general slot write with idle already high: no flush
        @(negedge clk);
        check(rsp_valid === 1'b0, "R8", "idle gap", 64'(rsp_valid), 64'd0);
        req_valid = 1'b1; req_index = 32'h104; req_hi = 32'h0404_0404; req_lo = 32'h4040_4040;
        pipe_idle = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        pipe_idle = 1'b0;
        model[4] = {32'h0404_0404, 32'h4040_4040};
        check(rsp_valid === 1'b1 && rsp_kind === 2'b00, "R5", "done after idle",
              64'({rsp_valid, rsp_kind}), 64'b100);
        check(tlb_flush_all === 1'b0, "R6", "general slot no flush", 64'(tlb_flush_all), 64'd0);
        check_bank("R1");

        @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule